// File: doc/BRIEF.md
# Programmable-Order Receive Channel Interrupt Selector

This block chooses one receive channel to report when several channels have a message waiting. Each channel has its own small order register, written by the host. The register holds a 4-bit rank, and a lower rank wins. Each cycle the block compares the ranks of all channels whose pending flag is set. It registers the index of the winning channel as the vector that the host reads, together with an interrupt request that is high while anything is pending.

The ranking is set entirely by software and does not follow a fixed channel order. Software is expected to give every channel a different rank. If two pending channels share a rank, the lower channel index wins, so the vector stays deterministic. The order registers are wider than the rank field, and their two upper bits are stored nowhere.

Top module: `chan_prio_sel`

## Requirements
- R1: After reset is released, irq_o is 0 and vec_o is 0. Channel k holds rank k, so with all channels pending channel 0 wins.
- R2: A clock edge with wr_en_i high copies wr_data_i[3:0] into the rank of channel wr_chan_i. If wr_chan_i is not below NUM_CH, the write changes nothing.
- R3: Among the pending channels, the one with the numerically smallest rank is reported on vec_o.
- R4: When pending channels share the smallest rank, the lowest channel index among them is reported.
- R5: irq_o equals the OR of pend_i sampled at the previous clock edge.
- R6: vec_o is registered. It reflects pend_i and the ranks as they stood at the previous clock edge, and it is 0 when nothing was pending.
- R7: wr_data_i bits 5:4 have no effect on which channel is selected.
- R8: A channel whose pend_i bit is 0 is never reported, whatever its rank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Rank register write strobe |
| wr_chan_i | input | CH_W | Channel whose rank is written |
| wr_data_i | input | REG_W (6) | Write data. Bits 3:0 are the rank; bits 5:4 are unused |
| pend_i | input | NUM_CH | Per-channel message-pending flags |
| irq_o | output | 1 | Interrupt request, registered |
| vec_o | output | CH_W | Index of the selected channel, registered |

## Verification
A rank write takes effect at the edge that samples it. A change on pend_i appears on irq_o and vec_o at the next rising edge, so every result is due exactly one edge after its stimulus. The bench drives all inputs on falling edges and reads the outputs on the following falling edge. A check therefore always sees the result of exactly one write or pending change. The sweep covers every combination of three 4-bit ranks, including all ties, against every pending pattern, with the unused bits varied. Each expected index is the minimum of rank times channel count plus index.

// File: rtl/chan_prio_pkg.sv
package chan_prio_pkg;
  localparam int unsigned DEF_NUM_CH = 3;
  localparam int unsigned PRIO_W     = 4;
  localparam int unsigned REG_W      = 6;
endpackage

// File: rtl/chan_prio_regs.sv
module chan_prio_regs #(
  parameter int unsigned NUM_CH = chan_prio_pkg::DEF_NUM_CH,
  parameter int unsigned PRIO_W = chan_prio_pkg::PRIO_W,
  parameter int unsigned REG_W  = chan_prio_pkg::REG_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_en_i,
  input  logic [CH_W-1:0]                wr_chan_i,
  input  logic [REG_W-1:0]               wr_data_i,
  output logic [NUM_CH-1:0][PRIO_W-1:0]  prio_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic [PRIO_W-1:0] prio_q;
    // only the rank field is stored; upper bits are dropped
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        prio_q <= PRIO_W'(g);
      else if (wr_en_i && (wr_chan_i == CH_W'(g)))
        prio_q <= wr_data_i[PRIO_W-1:0];
    end
    assign prio_o[g] = prio_q;
  end
endmodule

// File: rtl/chan_prio_arb.sv
module chan_prio_arb #(
  parameter int unsigned NUM_CH = chan_prio_pkg::DEF_NUM_CH,
  parameter int unsigned PRIO_W = chan_prio_pkg::PRIO_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]              pend_i,
  input  logic [NUM_CH-1:0][PRIO_W-1:0]  prio_i,
  output logic                           any_o,
  output logic [CH_W-1:0]                win_o
);
  logic [PRIO_W-1:0] best_prio;

  // strict less-than keeps the lower index on equal ranks
  always_comb begin
    any_o     = 1'b0;
    win_o     = '0;
    best_prio = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (pend_i[i] && (!any_o || prio_i[i] < best_prio)) begin
        any_o     = 1'b1;
        win_o     = CH_W'(i);
        best_prio = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/chan_prio_out.sv
module chan_prio_out #(
  parameter int unsigned NUM_CH = chan_prio_pkg::DEF_NUM_CH,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            any_i,
  input  logic [CH_W-1:0] win_i,
  output logic            irq_o,
  output logic [CH_W-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      vec_o <= '0;
    end else begin
      irq_o <= any_i;
      vec_o <= any_i ? win_i : '0;
    end
  end
endmodule

// File: rtl/chan_prio_sel.sv
module chan_prio_sel #(
  parameter int unsigned NUM_CH = chan_prio_pkg::DEF_NUM_CH,
  parameter int unsigned PRIO_W = chan_prio_pkg::PRIO_W,
  parameter int unsigned REG_W  = chan_prio_pkg::REG_W,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_chan_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic [NUM_CH-1:0] pend_i,
  output logic              irq_o,
  output logic [CH_W-1:0]   vec_o
);
  logic [NUM_CH-1:0][PRIO_W-1:0] prio_q;
  logic                          any_pend;
  logic [CH_W-1:0]               win_idx;

  chan_prio_regs #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .REG_W(REG_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_chan_i (wr_chan_i),
    .wr_data_i (wr_data_i),
    .prio_o    (prio_q)
  );

  chan_prio_arb #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W)) u_arb (
    .pend_i (pend_i),
    .prio_i (prio_q),
    .any_o  (any_pend),
    .win_o  (win_idx)
  );

  chan_prio_out #(.NUM_CH(NUM_CH)) u_out (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .any_i  (any_pend),
    .win_i  (win_idx),
    .irq_o  (irq_o),
    .vec_o  (vec_o)
  );
endmodule

// File: rtl/chan_prio_sel_chk.sv
module chan_prio_sel_chk #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned REG_W  = 6,
  localparam int unsigned CH_W  = $clog2(NUM_CH)
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          wr_en_i,
  input logic [CH_W-1:0]               wr_chan_i,
  input logic [REG_W-1:0]              wr_data_i,
  input logic [NUM_CH-1:0]             pend_i,
  input logic                          irq_o,
  input logic [CH_W-1:0]               vec_o,
  input logic [NUM_CH-1:0][PRIO_W-1:0] prio_q
);
  logic [NUM_CH-1:0]             pend_d;
  logic [NUM_CH-1:0][PRIO_W-1:0] prio_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_d <= '0;
      prio_d <= '0;
    end else begin
      pend_d <= pend_i;
      prio_d <= prio_q;
    end
  end

  a_r5_irq_follows_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|pend_d));

  a_r6_idle_vec_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == '0);

  a_r8_vec_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> int'(vec_o) < NUM_CH);

  a_r8_vec_was_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && int'(vec_o) < NUM_CH) |-> pend_d[vec_o]);

  for (genvar j = 0; j < NUM_CH; j++) begin : g_chk
    a_r3_lowest_rank: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && pend_d[j] && int'(vec_o) < NUM_CH) |-> prio_d[vec_o] <= prio_d[j]);

    a_r4_tie_low_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (irq_o && pend_d[j] && int'(vec_o) < NUM_CH && prio_d[j] == prio_d[vec_o])
        |-> vec_o <= CH_W'(j));

    a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_chan_i == CH_W'(j)) |=> prio_q[j] == $past(wr_data_i[PRIO_W-1:0]));
  end
endmodule

bind chan_prio_sel chan_prio_sel_chk #(.NUM_CH(NUM_CH), .PRIO_W(PRIO_W), .REG_W(REG_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_chan_i (wr_chan_i),
  .wr_data_i (wr_data_i),
  .pend_i    (pend_i),
  .irq_o     (irq_o),
  .vec_o     (vec_o),
  .prio_q    (prio_q)
);

// File: tb/chan_prio_sel_bench.sv
module chan_prio_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;
  localparam int CH_W = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [CH_W-1:0] wr_chan = '0;
  logic [5:0]      wr_data = '0;
  logic [2:0]      pend = '0;
  logic            irq;
  logic [CH_W-1:0] vec;

  int checks = 0;
  int errors = 0;
  int rank [3];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_prio_sel #(.NUM_CH(NUM_CH)) u_chan_prio_sel (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_chan_i(wr_chan),
    .wr_data_i(wr_data), .pend_i(pend), .irq_o(irq), .vec_o(vec)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_rank(input int ch, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = CH_W'(ch); wr_data = 6'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (ch < NUM_CH) rank[ch] = data & 15;
  endtask

  // expected winner: minimum of rank*NUM_CH+index over pending channels
  function automatic int exp_vec(input int p);
    int best = 1 << 30;
    for (int k = 0; k < NUM_CH; k++)
      if (p[k] && rank[k] * NUM_CH + k < best) best = rank[k] * NUM_CH + k;
    return (best == (1 << 30)) ? 0 : best % NUM_CH;
  endfunction

  task automatic apply_and_check(input int p, input string req);
    pend = 3'(p);
    @(negedge clk);
    check({req, " irq R5"}, int'(irq), (p != 0) ? 1 : 0);
    check({req, " vec R6"}, int'(vec), exp_vec(p));
  endtask

  initial begin
    for (int k = 0; k < NUM_CH; k++) rank[k] = k;
    repeat (3) @(negedge clk);
    check("R1 irq after reset", int'(irq), 0);
    check("R1 vec after reset", int'(vec), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq idle", int'(irq), 0);
    check("R1 vec idle", int'(vec), 0);
    apply_and_check(7, "R1 default ranks");
    apply_and_check(6, "R1 default ranks");

    // R3 R4 R7 R8: every rank triple (ties included) vs every pending set
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int c = 0; c < 16; c++) begin
          int hi;
          hi = ((a + b + c) & 3) << 4;
          write_rank(0, hi | a);
          write_rank(1, hi | b);
          write_rank(2, ((a ^ c) & 3) << 4 | c);
          for (int p = 0; p < 8; p++)
            apply_and_check(p, "R3 R4 R7 R8 R2");
        end

    // R2: write to a channel index beyond NUM_CH changes nothing
    write_rank(0, 5); write_rank(1, 9); write_rank(2, 7);
    apply_and_check(7, "R2 before");
    write_rank(3, 0);
    apply_and_check(7, "R2 out of range");
    apply_and_check(6, "R2 out of range");
    // R7: upper bits alone do not change ranks
    write_rank(2, 6'h37);
    apply_and_check(7, "R7 upper bits");
    apply_and_check(0, "R6 back to idle");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule